// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits beside the transmit and receive FIFOs of an SPI controller and turns their fill levels and push/pop strobes into status flags, interrupt vectors, a single interrupt line and two DMA request lines. The FIFO storage and the serial shifter live elsewhere. This unit only watches the level counts and the strobes that move entries in and out.

Software programs it through a small write/read register port. The port holds an interrupt mask, a write-only clear register, two interrupt thresholds, two DMA data levels and a pair of DMA enables. Three error events are sticky: a push into a full transmit FIFO, a push into a full receive FIFO and a pop from an empty receive FIFO. The two level interrupts follow the fill counts continuously and need no clearing. A threshold write whose value is not smaller than the FIFO depth is dropped, so software can find the depth by writing and reading back.

Top module: `spi_fifo_status_irq`

## Requirements
- R1: `status` is combinational from the inputs. Bit 0 is `engineBusy`, bit 1 is transmit level equal to DEPTH, bit 2 is transmit level zero, bit 3 is receive level zero and bit 4 is receive level equal to DEPTH.
- R2: `rawIrq` bit 0 is high while the transmit level is at or below the transmit interrupt threshold. `rawIrq` bit 4 is high while the receive level is above the receive interrupt threshold. Both follow the levels in the same cycle.
- R3: `rawIrq` bits 1 to 3 are sticky and are set in the cycle after their event. Bit 1 is set by `txPush` with the transmit level at DEPTH. Bit 2 is set by `rxPop` with the receive level at zero. Bit 3 is set by `rxPush` with the receive level at DEPTH. Each bit stays set until it is cleared.
- R4: A write to the clear register (address 1) acts bit by bit on the written data. Data bit 0 clears all three sticky bits. Data bit 1 clears receive underflow, data bit 2 clears receive overflow and data bit 3 clears transmit overflow. The register always reads 0.
- R5: If a sticky event and its clear fall in the same cycle, the event wins and the bit ends up set.
- R6: The mask (address 0, bits 4:0) resets to zero. `maskedIrq` equals `rawIrq` AND mask, and `irqOut` is the OR of `maskedIrq`.
- R7: `txDmaReq` is high while DMA enable bit 1 is set and the transmit level is at or below the transmit DMA level. `rxDmaReq` is high while DMA enable bit 0 is set and the receive level is above the receive DMA level. The DMA enables are at address 6.
- R8: Addresses 2, 3, 4 and 5 hold the transmit interrupt threshold, the receive interrupt threshold, the transmit DMA level and the receive DMA level. A write of a value of DEPTH or more leaves the register unchanged.
- R9: `regRdData` returns the register selected by `regAddr` combinationally, and addresses 1 and 7 read zero. A write becomes visible in the cycle after `regWrEn`.
- R10: After reset all registers and sticky bits are zero. With both levels at zero this gives `status` = 5'b01100, `rawIrq` = 5'b00001, `irqOut` low and both DMA requests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txLevel | input | LVL_W | Transmit FIFO entry count |
| rxLevel | input | LVL_W | Receive FIFO entry count |
| txPush | input | 1 | Write strobe into the transmit FIFO |
| rxPush | input | 1 | Write strobe into the receive FIFO from the shifter |
| rxPop | input | 1 | Read strobe from the receive FIFO |
| engineBusy | input | 1 | Serial engine is shifting |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | REG_W | Register write data |
| regRdData | output | REG_W | Read data for `regAddr` |
| status | output | 5 | Status flags |
| rawIrq | output | 5 | Unmasked interrupt sources |
| maskedIrq | output | 5 | Interrupt sources after the mask |
| irqOut | output | 1 | Combined interrupt |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |

## Verification
A sticky error event and a clear write can land in the same cycle. The precedence rule decides the outcome: an overflow or underflow that arrives while software clears that same bit must not be lost. The bench forces this directly: it pushes into a full transmit FIFO in the same cycle it writes the transmit-overflow clear bit, and it expects the bit to remain set. A long random phase then mixes clear writes with push and pop events at the empty and full levels. A behavioural model is compared against every output on every cycle, so any collision the random phase produces is judged as well.

// File: rtl/spi_fsi_pkg.sv
`timescale 1ns/1ps
package spi_fsi_pkg;
  localparam int N_IRQ    = 5;
  localparam int N_STICKY = 3;  // 0 tx overflow, 1 rx underflow, 2 rx overflow
  localparam int N_THR    = 4;  // tx irq, rx irq, tx dma, rx dma

  localparam logic [2:0] ADDR_MASK     = 3'd0;
  localparam logic [2:0] ADDR_CLEAR    = 3'd1;
  localparam logic [2:0] ADDR_THR_BASE = 3'd2;
  localparam logic [2:0] ADDR_DMA_EN   = 3'd6;

  typedef struct packed {
    logic [N_STICKY-1:0] setEvt;
    logic [N_STICKY-1:0] clrEvt;
  } evtStrb_t;
endpackage

// File: rtl/spi_fsi_ctrl.sv
`timescale 1ns/1ps
module spi_fsi_ctrl
  import spi_fsi_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int REG_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             txPush,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  output evtStrb_t         strb,
  output logic [N_IRQ-1:0] maskQ,
  output logic [1:0]       dmaEnQ,
  output logic [THR_W-1:0] txIrqThr,
  output logic [THR_W-1:0] rxIrqThr,
  output logic [THR_W-1:0] txDmaLvl,
  output logic [THR_W-1:0] rxDmaLvl,
  output logic [REG_W-1:0] regRdData
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [THR_W-1:0] thrQ [N_THR];
  logic             clrWr;
  logic             thrOk;

  assign clrWr = regWrEn && (regAddr == ADDR_CLEAR);
  assign thrOk = regWrData < REG_W'(DEPTH);

  // Event detection, index order matches rawIrq bits 1..3
  assign strb.setEvt[0] = txPush && (txLevel == FULL_LVL);
  assign strb.setEvt[1] = rxPop  && (rxLevel == '0);
  assign strb.setEvt[2] = rxPush && (rxLevel == FULL_LVL);
  assign strb.clrEvt[0] = clrWr && (regWrData[0] || regWrData[3]);
  assign strb.clrEvt[1] = clrWr && (regWrData[0] || regWrData[1]);
  assign strb.clrEvt[2] = clrWr && (regWrData[0] || regWrData[2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      dmaEnQ <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_MASK)   maskQ  <= regWrData[N_IRQ-1:0];
      if (regAddr == ADDR_DMA_EN) dmaEnQ <= regWrData[1:0];
    end
  end

  for (genvar g = 0; g < N_THR; g++) begin : gThr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        thrQ[g] <= '0;
      else if (regWrEn && thrOk && (regAddr == ADDR_THR_BASE + 3'(g)))
        thrQ[g] <= regWrData[THR_W-1:0];
    end
  end

  assign txIrqThr = thrQ[0];
  assign rxIrqThr = thrQ[1];
  assign txDmaLvl = thrQ[2];
  assign rxDmaLvl = thrQ[3];

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_MASK:          regRdData = REG_W'(maskQ);
      ADDR_THR_BASE:      regRdData = REG_W'(thrQ[0]);
      ADDR_THR_BASE + 3'd1: regRdData = REG_W'(thrQ[1]);
      ADDR_THR_BASE + 3'd2: regRdData = REG_W'(thrQ[2]);
      ADDR_THR_BASE + 3'd3: regRdData = REG_W'(thrQ[3]);
      ADDR_DMA_EN:        regRdData = REG_W'(dmaEnQ);
      default:            regRdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_fsi_datapath.sv
`timescale 1ns/1ps
module spi_fsi_datapath
  import spi_fsi_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  evtStrb_t         strb,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             engineBusy,
  input  logic [N_IRQ-1:0] maskQ,
  input  logic [1:0]       dmaEnQ,
  input  logic [THR_W-1:0] txIrqThr,
  input  logic [THR_W-1:0] rxIrqThr,
  input  logic [THR_W-1:0] txDmaLvl,
  input  logic [THR_W-1:0] rxDmaLvl,
  output logic [4:0]       status,
  output logic [N_IRQ-1:0] rawIrq,
  output logic [N_IRQ-1:0] maskedIrq,
  output logic             irqOut,
  output logic             txDmaReq,
  output logic             rxDmaReq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [N_STICKY-1:0] stickyQ;

  // Set has priority over clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stickyQ <= '0;
    else       stickyQ <= (stickyQ & ~strb.clrEvt) | strb.setEvt;
  end

  assign status = {rxLevel == FULL_LVL, rxLevel == '0,
                   txLevel == '0, txLevel == FULL_LVL, engineBusy};

  assign rawIrq = {rxLevel > LVL_W'(rxIrqThr), stickyQ,
                   txLevel <= LVL_W'(txIrqThr)};
  assign maskedIrq = rawIrq & maskQ;
  assign irqOut    = |maskedIrq;

  assign txDmaReq = dmaEnQ[1] && (txLevel <= LVL_W'(txDmaLvl));
  assign rxDmaReq = dmaEnQ[0] && (rxLevel >  LVL_W'(rxDmaLvl));
endmodule

// File: rtl/spi_fifo_status_irq.sv
`timescale 1ns/1ps
module spi_fifo_status_irq
  import spi_fsi_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int REG_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             txPush,
  input  logic             rxPush,
  input  logic             rxPop,
  input  logic             engineBusy,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic [4:0]       status,
  output logic [N_IRQ-1:0] rawIrq,
  output logic [N_IRQ-1:0] maskedIrq,
  output logic             irqOut,
  output logic             txDmaReq,
  output logic             rxDmaReq
);
  evtStrb_t         strb;
  logic [N_IRQ-1:0] maskQ;
  logic [1:0]       dmaEnQ;
  logic [THR_W-1:0] txIrqThr, rxIrqThr, txDmaLvl, rxDmaLvl;

  spi_fsi_ctrl #(.DEPTH(DEPTH), .REG_W(REG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .txPush(txPush), .rxPush(rxPush), .rxPop(rxPop),
    .txLevel(txLevel), .rxLevel(rxLevel), .strb(strb), .maskQ(maskQ),
    .dmaEnQ(dmaEnQ), .txIrqThr(txIrqThr), .rxIrqThr(rxIrqThr),
    .txDmaLvl(txDmaLvl), .rxDmaLvl(rxDmaLvl), .regRdData(regRdData)
  );

  spi_fsi_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .txLevel(txLevel),
    .rxLevel(rxLevel), .engineBusy(engineBusy), .maskQ(maskQ),
    .dmaEnQ(dmaEnQ), .txIrqThr(txIrqThr), .rxIrqThr(rxIrqThr),
    .txDmaLvl(txDmaLvl), .rxDmaLvl(rxDmaLvl), .status(status),
    .rawIrq(rawIrq), .maskedIrq(maskedIrq), .irqOut(irqOut),
    .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );
endmodule

// File: rtl/spi_fsi_checker.sv
`timescale 1ns/1ps
module spi_fsi_checker
  import spi_fsi_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int REG_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic             txPush,
  input logic             rxPush,
  input logic             rxPop,
  input logic             regWrEn,
  input logic [2:0]       regAddr,
  input logic [REG_W-1:0] regWrData,
  input logic [N_IRQ-1:0] rawIrq,
  input logic             irqOut,
  input logic             txDmaReq,
  input logic             rxDmaReq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  AST_TX_OVF_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    txPush && txLevel == FULL_LVL |=> rawIrq[1]);  // R3
  AST_RX_UDF_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    rxPop && rxLevel == '0 |=> rawIrq[2]);  // R3
  AST_RX_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rawIrq[3] && !(regWrEn && regAddr == ADDR_CLEAR) |=> rawIrq[3]);  // R3
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_CLEAR && regWrData[0] && !txPush && !rxPush && !rxPop
    |=> rawIrq[3:1] == 3'b000);  // R4
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_CLEAR && regWrData[3] && txPush && txLevel == FULL_LVL
    |=> rawIrq[1]);  // R5
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_MASK && regWrData[4:0] == 5'd0 |=> !irqOut);  // R6
  AST_DMA_OFF: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == ADDR_DMA_EN && regWrData[1:0] == 2'd0
    |=> !txDmaReq && !rxDmaReq);  // R7
endmodule

bind spi_fifo_status_irq spi_fsi_checker #(.DEPTH(DEPTH), .REG_W(REG_W)) chk_i (
  .clk(clk), .rstN(rstN), .txLevel(txLevel), .rxLevel(rxLevel),
  .txPush(txPush), .rxPush(rxPush), .rxPop(rxPop), .regWrEn(regWrEn),
  .regAddr(regAddr), .regWrData(regWrData), .rawIrq(rawIrq),
  .irqOut(irqOut), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
);

// File: tb/spi_fifo_status_irq_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_status_irq_tb_top;
  localparam int DEPTH = 32;
  localparam int REG_W = 8;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LVL_W-1:0] txLevel = '0, rxLevel = '0;
  logic txPush = 0, rxPush = 0, rxPop = 0, engineBusy = 0, regWrEn = 0;
  logic [2:0] regAddr = '0;
  logic [REG_W-1:0] regWrData = '0;
  logic [REG_W-1:0] regRdData;
  logic [4:0] status, rawIrq, maskedIrq;
  logic irqOut, txDmaReq, rxDmaReq;

  int checks = 0, failures = 0;
  bit finished = 0, running = 0;

  // behavioural reference state
  int mMask = 0, mDma = 0;
  int mThr[4] = '{0, 0, 0, 0};
  bit mTxOvf = 0, mRxUdf = 0, mRxOvf = 0;

  always #10 clk = ~clk;

  spi_fifo_status_irq #(.DEPTH(DEPTH), .REG_W(REG_W)) dut_i (
    .clk(clk), .rstN(rstN), .txLevel(txLevel), .rxLevel(rxLevel),
    .txPush(txPush), .rxPush(rxPush), .rxPop(rxPop), .engineBusy(engineBusy),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .status(status), .rawIrq(rawIrq),
    .maskedIrq(maskedIrq), .irqOut(irqOut), .txDmaReq(txDmaReq),
    .rxDmaReq(rxDmaReq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mMask = 0; mDma = 0; mThr = '{0, 0, 0, 0};
      mTxOvf = 0; mRxUdf = 0; mRxOvf = 0;
    end else begin
      bit eTx, eRu, eRo;
      eTx = txPush && txLevel == DEPTH;
      eRu = rxPop && rxLevel == 0;
      eRo = rxPush && rxLevel == DEPTH;
      if (regWrEn && regAddr == 1) begin
        if (regWrData[0] || regWrData[3]) mTxOvf = 0;
        if (regWrData[0] || regWrData[1]) mRxUdf = 0;
        if (regWrData[0] || regWrData[2]) mRxOvf = 0;
      end
      if (eTx) mTxOvf = 1;
      if (eRu) mRxUdf = 1;
      if (eRo) mRxOvf = 1;
      if (regWrEn) begin
        if (regAddr == 0) mMask = regWrData & 31;
        if (regAddr == 6) mDma = regWrData & 3;
        if (regAddr >= 2 && regAddr <= 5 && regWrData < DEPTH) mThr[regAddr-2] = regWrData;
      end
    end
  end

  function automatic int expRaw();
    return ((rxLevel > mThr[1]) << 4) | (mRxOvf << 3) | (mRxUdf << 2) |
           (mTxOvf << 1) | (txLevel <= mThr[0]);
  endfunction

  always @(negedge clk) if (running) begin
    int er, em, rd;
    er = expRaw();
    em = er & mMask;
    case (regAddr)
      0: rd = mMask;
      2, 3, 4, 5: rd = mThr[regAddr-2];
      6: rd = mDma;
      default: rd = 0;
    endcase
    chk("R1 status", status, ((rxLevel == DEPTH) << 4) | ((rxLevel == 0) << 3) |
        ((txLevel == 0) << 2) | ((txLevel == DEPTH) << 1) | engineBusy);
    chk("R2 level irqs", {rawIrq[4], rawIrq[0]}, ((er >> 3) & 2) | (er & 1));
    chk("R3 sticky irqs", rawIrq[3:1], (er >> 1) & 7);
    chk("R6 masked", maskedIrq, em);
    chk("R6 irqOut", irqOut, em != 0);
    chk("R7 txDmaReq", txDmaReq, mDma[1] && txLevel <= mThr[2]);
    chk("R7 rxDmaReq", rxDmaReq, mDma[0] && rxLevel > mThr[3]);
    chk("R9 readback", regRdData, rd);
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic wr(int a, int d);
    regWrEn = 1; regAddr = 3'(a); regWrData = REG_W'(d);
    cyc();
    regWrEn = 0;
  endtask

  initial begin
    running = 1;
    repeat (3) cyc();
    // R10 reset state
    chk("R10 status", status, 5'b01100);
    chk("R10 rawIrq", rawIrq, 5'b00001);
    chk("R10 irqOut", irqOut, 0);
    chk("R10 dma", {txDmaReq, rxDmaReq}, 0);
    rstN = 1;
    cyc();
    // R3 events
    txLevel = 6'(DEPTH); txPush = 1; cyc(); txPush = 0;
    chk("R3 tx overflow", rawIrq[1], 1);
    rxPop = 1; cyc(); rxPop = 0;
    chk("R3 rx underflow", rawIrq[2], 1);
    rxLevel = 6'(DEPTH); rxPush = 1; cyc(); rxPush = 0;
    chk("R3 rx overflow", rawIrq[3], 1);
    repeat (3) cyc();
    chk("R3 held", rawIrq[3:1], 3'b111);
    // R4 per-bit clear then clear all
    wr(1, 2);
    chk("R4 clear underflow only", rawIrq[3:1], 3'b101);
    chk("R4 clear reads zero", regRdData, 0);
    wr(1, 1);
    chk("R4 clear all", rawIrq[3:1], 3'b000);
    // R5 event and clear in the same cycle
    txPush = 1; regWrEn = 1; regAddr = 3'd1; regWrData = 8'h08; cyc();
    txPush = 0; regWrEn = 0;
    chk("R5 set wins", rawIrq[1], 1);
    // R6 mask
    wr(0, 2);
    chk("R6 irq with mask", irqOut, 1);
    wr(0, 0);
    chk("R6 irq masked off", irqOut, 0);
    // R8 threshold acceptance
    wr(2, 7);
    chk("R8 thr accept", regRdData, 7);
    wr(2, DEPTH + 8);
    chk("R8 thr reject", regRdData, 7);
    wr(2, DEPTH - 1);
    chk("R8 thr max", regRdData, DEPTH - 1);
    // R7 dma
    wr(4, 4); wr(6, 2);
    txLevel = 6'd4; cyc();
    chk("R7 tx dma at level", txDmaReq, 1);
    txLevel = 6'd5; cyc();
    chk("R7 tx dma above level", txDmaReq, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 8;
      txLevel = (r == 0) ? 0 : (r == 1) ? 6'(DEPTH) : 6'($urandom % (DEPTH + 1));
      r = $urandom % 8;
      rxLevel = (r == 0) ? 0 : (r == 1) ? 6'(DEPTH) : 6'($urandom % (DEPTH + 1));
      txPush = ($urandom % 4) == 0;
      rxPush = ($urandom % 4) == 0;
      rxPop  = ($urandom % 4) == 0;
      engineBusy = $urandom % 2;
      regWrEn = ($urandom % 3) == 0;
      regAddr = 3'($urandom % 8);
      regWrData = 8'($urandom % 64);
      cyc();
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule